// File: doc/BRIEF.md
# Reference Bit Aging Tracker

This block keeps an approximate least-recently-used order over a fixed pool of physical frames. Every frame has one reference flag and one idle counter. A touch on the access port raises the flag of the addressed frame. When the periodic interval tick arrives, every frame is updated in the same cycle. A frame whose flag is clear adds one to its idle counter. A frame whose flag is set has its counter cleared to zero. All flags are then cleared.

The counter therefore holds the number of intervals since the frame was last used. The frame with the largest counter is offered as the replacement candidate. Its index and its counter value are presented on registered outputs. A replacement engine samples these outputs whenever it needs a victim. No timestamps are stored per access. Allocation and the eviction action are left to the surrounding logic.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset every idle counter and every reference flag is zero, and the outputs show frame 0 with age 0.
- R2: A touch with `touch_valid`=1 sets the flag of frame `touch_frame`, so the next tick clears that frame's counter to 0.
- R3: On a tick, each frame whose flag is clear increments its counter by one.
- R4: A counter at its maximum value (2^CNT_W-1, which is 255 by default) stays at that value on later idle ticks and does not wrap.
- R5: A tick clears every flag, so a frame touched only before one tick increments again on the following tick.
- R6: `victim_frame` gives the index of the frame with the largest counter, and `victim_age` gives that counter's value. When several frames share the largest value, the lowest index wins.
- R7: A touch in the same cycle as a tick is kept. It is applied after the flag clear, so the frame is treated as referenced on the next tick.
- R8: The outputs follow a change in the counters exactly one clock cycle after the edge that changed them.
- R9: Without a tick, touches leave every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_valid | input | 1 | Marks that a frame was read or written this cycle |
| touch_frame | input | IDX_W | Index of the touched frame |
| tick | input | 1 | Interval tick: ages all frames in one cycle |
| victim_frame | output | IDX_W | Index of the least recently used frame |
| victim_age | output | CNT_W | Idle count of that frame |

## Verification
The block is driven with a table of mixed touches and ticks. In that table, touched frames and idle frames diverge. The argmax moves between frames, and ties arise that only lowest-index priority can settle. This separates a design that resets on the flag from one that ignores it. Directed sequences target the harder timing cases. They apply a touch in the tick cycle, ticks with no touch after a reference, and touches with no tick. They also sample once before and once after the one-cycle output register. A long run of idle ticks drives the counters into saturation, and partial touches then test a tie at the maximum value.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;
    localparam int DEF_FRAMES = 8;
    localparam int DEF_CNT_W  = 8;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_AGE   = 2'd2,
        OP_PIN   = 2'd3
    } age_op_e;
endpackage

// File: rtl/age_cell.sv
module age_cell
    import lru_age_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             touch,
    output logic [CNT_W-1:0] age
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             refd;
        logic [CNT_W-1:0] cnt;
    } cell_t;

    cell_t   s_d, s_q;
    age_op_e op_d;

    always_comb begin
        s_d = s_q;
        if (!tick)                op_d = OP_HOLD;
        else if (s_q.refd)        op_d = OP_CLEAR;
        else if (s_q.cnt == CNT_MAX) op_d = OP_PIN;
        else                      op_d = OP_AGE;
        case (op_d)
            OP_CLEAR: s_d.cnt = '0;
            OP_AGE:   s_d.cnt = s_q.cnt + 1'b1;
            default:  s_d.cnt = s_q.cnt;
        endcase
        if (tick)  s_d.refd = 1'b0;
        if (touch) s_d.refd = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign age = s_q.cnt;

    // R2: a referenced frame restarts from zero on the tick
    p_ref_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.refd) |=> (s_q.cnt == '0));
    // R3: an idle frame below the limit gains exactly one
    p_idle_ages_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !s_q.refd && s_q.cnt != CNT_MAX) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));
    // R4: no wrap past the limit
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !s_q.refd && s_q.cnt == CNT_MAX) |=> (s_q.cnt == CNT_MAX));
    // R7: a touch in the tick cycle survives the clear
    p_touch_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && touch) |=> s_q.refd);
    // R5: a tick without touch leaves the flag clear
    p_flag_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !touch) |=> !s_q.refd);
    // R9: counters only move on a tick
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.cnt));
endmodule

// File: rtl/oldest_finder.sv
module oldest_finder
    import lru_age_pkg::*;
#(
    parameter int NUM_FRAMES = DEF_FRAMES,
    parameter int CNT_W      = DEF_CNT_W,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES*CNT_W-1:0] ages_flat,
    output logic [IDX_W-1:0]            best_idx,
    output logic [CNT_W-1:0]            best_age
);
    always_comb begin
        best_idx = '0;
        best_age = ages_flat[CNT_W-1:0];
        for (int i = 1; i < NUM_FRAMES; i++) begin
            if (ages_flat[i*CNT_W +: CNT_W] > best_age) begin
                best_age = ages_flat[i*CNT_W +: CNT_W];
                best_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
    import lru_age_pkg::*;
#(
    parameter int NUM_FRAMES = DEF_FRAMES,
    parameter int CNT_W      = DEF_CNT_W,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_valid,
    input  logic [IDX_W-1:0] touch_frame,
    input  logic             tick,
    output logic [IDX_W-1:0] victim_frame,
    output logic [CNT_W-1:0] victim_age
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] age;
    } pick_t;

    logic [NUM_FRAMES*CNT_W-1:0] ages_flat;
    logic [IDX_W-1:0]            best_idx;
    logic [CNT_W-1:0]            best_age;
    pick_t                       pick_d, pick_q;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cell
        logic hit;
        assign hit = touch_valid && (touch_frame == IDX_W'(g));
        age_cell #(.CNT_W(CNT_W)) i_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .touch (hit),
            .age   (ages_flat[g*CNT_W +: CNT_W])
        );
    end

    oldest_finder #(
        .NUM_FRAMES (NUM_FRAMES),
        .CNT_W      (CNT_W),
        .IDX_W      (IDX_W)
    ) i_finder (
        .ages_flat (ages_flat),
        .best_idx  (best_idx),
        .best_age  (best_age)
    );

    always_comb begin
        pick_d.idx = best_idx;
        pick_d.age = best_age;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pick_q <= '0;
        else        pick_q <= pick_d;
    end

    assign victim_frame = pick_q.idx;
    assign victim_age   = pick_q.age;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_chk
        // R6, R8: registered pick dominates last cycle's counters, ties to lowest index
        p_dominates_r6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (victim_age >= $past(ages_flat[g*CNT_W +: CNT_W])));
        p_lowest_tie_r6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((IDX_W'(g) >= victim_frame) ||
                      ($past(ages_flat[g*CNT_W +: CNT_W]) < victim_age)));
    end
    // R8: reported age is the reported frame's counter from one cycle earlier
    p_age_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (victim_age == $past(ages_flat[pick_d.idx*CNT_W +: CNT_W])));
endmodule

// File: tb/test_lru_age_tracker.sv
module test_lru_age_tracker;
    localparam int N = 8;
    localparam int W = 8;
    localparam int MAXV = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       touch_valid = 1'b0;
    logic [2:0] touch_frame = '0;
    logic       tick = 1'b0;
    logic [2:0] victim_frame;
    logic [7:0] victim_age;

    int errors = 0;
    int checks = 0;
    int m_cnt [N];
    bit m_ref [N];

    always #4 clk = ~clk;

    lru_age_tracker #(.NUM_FRAMES(N), .CNT_W(W)) i_lru_age_tracker (
        .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid),
        .touch_frame(touch_frame), .tick(tick),
        .victim_frame(victim_frame), .victim_age(victim_age)
    );

    typedef struct packed {
        logic       t_en;
        logic [2:0] fr;
        logic       tk;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 1'b1}, '{1'b1, 3'd0, 1'b0}, '{1'b1, 3'd3, 1'b0},
        '{1'b0, 3'd0, 1'b1}, '{1'b1, 3'd1, 1'b1}, '{1'b0, 3'd0, 1'b1},
        '{1'b1, 3'd2, 1'b0}, '{1'b1, 3'd4, 1'b0}, '{1'b0, 3'd0, 1'b1},
        '{1'b1, 3'd5, 1'b1}, '{1'b1, 3'd6, 1'b0}, '{1'b0, 3'd0, 1'b1},
        '{1'b1, 3'd7, 1'b0}, '{1'b1, 3'd0, 1'b0}, '{1'b0, 3'd0, 1'b1},
        '{1'b1, 3'd1, 1'b0}, '{1'b0, 3'd0, 1'b1}, '{1'b1, 3'd3, 1'b1},
        '{1'b0, 3'd0, 1'b1}, '{1'b0, 3'd0, 1'b1}
    };

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_ref[i] = 1'b0; end
    endtask

    task automatic model_step(input bit t_en, input int fr, input bit tk);
        if (tk) begin
            for (int i = 0; i < N; i++) begin
                if (m_ref[i])          m_cnt[i] = 0;
                else if (m_cnt[i] < MAXV) m_cnt[i] = m_cnt[i] + 1;
                m_ref[i] = 1'b0;
            end
        end
        if (t_en) m_ref[fr] = 1'b1;
    endtask

    task automatic expect_pick(input string req);
        int bi = 0;
        int ba = m_cnt[0];
        for (int i = 1; i < N; i++) if (m_cnt[i] > ba) begin ba = m_cnt[i]; bi = i; end
        checks++;
        if (victim_frame != 3'(bi) || victim_age != 8'(ba)) begin
            errors++;
            $display("FAIL %s: frame=%0d age=%0d expected frame=%0d age=%0d",
                     req, victim_frame, victim_age, bi, ba);
        end
    endtask

    // one stimulus cycle, then one idle cycle for the output register; sample at negedge
    task automatic apply(input bit t_en, input int fr, input bit tk);
        touch_valid = t_en; touch_frame = 3'(fr); tick = tk;
        @(negedge clk);
        touch_valid = 1'b0; tick = 1'b0;
        model_step(t_en, fr, tk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        expect_pick("R1 reset state");

        // table walk: mixed touches and ticks against the model (R6)
        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].t_en, int'(VECS[v].fr), VECS[v].tk);
            expect_pick("R6 table");
        end

        do_reset();
        apply(1'b0, 0, 1'b1);
        expect_pick("R3 idle tick increments");          // all 1 -> frame 0 age 1
        apply(1'b1, 0, 1'b0);
        expect_pick("R9 touch without tick holds");      // frame 0 age 1
        apply(1'b0, 0, 1'b1);
        expect_pick("R2 touched frame cleared");         // frame 1 age 2
        for (int f = 1; f < N; f++) apply(1'b1, f, 1'b0);
        apply(1'b0, 0, 1'b1);
        expect_pick("R5 flag cleared by earlier tick");  // frame 0 age 1
        apply(1'b1, 0, 1'b1);
        expect_pick("R7 touch in tick cycle");           // frame 0 age 2
        apply(1'b0, 0, 1'b1);
        expect_pick("R7 kept touch clears counter");     // frame 1 age 2

        // R8: counters change at the tick edge, outputs one edge later
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        checks++;
        if (victim_frame != 3'd1 || victim_age != 8'd2) begin
            errors++;
            $display("FAIL R8 early: frame=%0d age=%0d expected frame=1 age=2", victim_frame, victim_age);
        end
        model_step(1'b0, 0, 1'b1);
        @(negedge clk);
        expect_pick("R8 one cycle later");               // frame 1 age 3

        do_reset();
        for (int k = 0; k < 260; k++) apply(1'b0, 0, 1'b1);
        expect_pick("R4 saturation");                    // frame 0 age 255
        for (int f = 0; f < 4; f++) apply(1'b1, f, 1'b0);
        apply(1'b0, 0, 1'b1);
        expect_pick("R4 R6 tie at maximum");             // frame 4 age 255

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule